// File: doc/BRIEF.md
# Call-Scrubbing Register File

This block is the architectural register store of a small 64-bit packet and event filter processor. It holds eleven 64-bit registers, indexed 0 to 10. Index 10 is the frame pointer: programs can read it, but only the start sequence can load it. The file has two combinational read ports and one write port. A width flag on the write port chooses between storing a full 64-bit result and storing a 32-bit result that is zero-extended.

Every register carries a validity bit. When the sequencer starts a program, the file takes the context pointer into register 1 and the frame pointer into register 10. These two are then the only readable registers. When a helper call finishes, the returned value lands in register 0. The five argument registers (1 to 5) lose their validity, and the callee-saved registers (6 to 9) keep their contents and their validity. A read of a register that is not valid returns zero and raises an error flag. A write aimed at the frame pointer, or at an index above 10, is discarded and raises a separate error flag.

Top module: `scrub_regfile`

## Requirements
- R1: A write request to index 10 or to any index from 11 to 15 leaves every register unchanged. In the same cycle it raises `illegalWrite`, which is combinational on `wrEn` and `wrAddr`.
- R2: A write with `wrWide`=0 stores `wrData[31:0]` in bits 31:0 of the target register and zero in bits 63:32. A write with `wrWide`=1 stores all 64 bits.
- R3: After a clock edge with `callDone`=1 and `start`=0, register 0 holds `callRet` and is valid, and registers 1 to 5 are invalid.
- R4: A `callDone` edge changes neither the contents nor the validity of registers 6 to 9.
- R5: After a clock edge with `start`=1, register 1 holds `ctxPtr` and register 10 holds `framePtr`. These two are then the only valid registers. On the same edge, `start` overrides both `callDone` and a write.
- R6: A read port whose index names an invalid register, or an index above 10, drives zero. `illegalRead` is high in any cycle in which an enabled read port (`rdEnA` or `rdEnB` = 1) names such an index.
- R7: A legal write to an index from 0 to 9 stores the data and makes that register valid. The new value appears on the read ports in the cycle after the clock edge, because reads are combinational on the stored state.
- R8: When `callDone` and a write are both present on the same edge, the write is discarded, including a write to a callee-saved register.
- R9: While `rstN` is low, every register is invalid, and every read port returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all updates on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Program start: load context and frame pointers |
| ctxPtr | input | 64 | Context pointer loaded into register 1 on start |
| framePtr | input | 64 | Frame pointer loaded into register 10 on start |
| callDone | input | 1 | Helper call has returned this cycle |
| callRet | input | 64 | Value returned by the helper call |
| wrEn | input | 1 | Write request |
| wrAddr | input | 4 | Write index |
| wrWide | input | 1 | 1 = 64-bit write, 0 = 32-bit zero-extended write |
| wrData | input | 64 | Write data |
| rdEnA | input | 1 | Port A read is in use (drives error flagging) |
| rdAddrA | input | 4 | Port A read index |
| rdDataA | output | 64 | Port A read data, zero when invalid |
| rdEnB | input | 1 | Port B read is in use |
| rdAddrB | input | 4 | Port B read index |
| rdDataB | output | 64 | Port B read data, zero when invalid |
| illegalRead | output | 1 | An enabled port names an invalid or nonexistent register |
| illegalWrite | output | 1 | Write requested to the frame pointer or a nonexistent index |

## Verification
Directed phases first fill every writable register with 64-bit patterns, then with 32-bit writes whose upper data bits are all ones. A zero-extension fault therefore shows up as ones in the upper half, where a stale value could not hide it. Calls are issued together with writes to an argument register and to a callee-saved register, which separates a wrong priority order from a wrong scrub mask. The start strobe is applied together with a call and a write to show that it overrides both. A long randomized stretch then mixes all strobes and both read ports, including indices 11 to 15. A behavioural model compares every output in every cycle.

// File: rtl/scrub_rf_pkg.sv
package scrub_rf_pkg;

  localparam int REG_CNT   = 11;
  localparam int IDX_W     = 4;
  localparam int RET_IDX   = 0;
  localparam int CTX_IDX   = 1;
  localparam int ARG_FIRST = 1;
  localparam int ARG_LAST  = 5;
  localparam int FP_IDX    = 10;
  localparam int ADDR_SPAN = 1 << IDX_W;

  // Strobes from the control half to the storage half
  typedef struct packed {
    logic             loadStart;
    logic             loadCall;
    logic             commitWr;
    logic [IDX_W-1:0] wrIdx;
    logic             wrWide;
  } rfStrobes_t;

endpackage

// File: rtl/scrub_rf_ctrl.sv
module scrub_rf_ctrl
  import scrub_rf_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               callDone,
  input  logic               wrEn,
  input  logic [IDX_W-1:0]   wrAddr,
  input  logic               wrWide,
  input  logic               rdEnA,
  input  logic [IDX_W-1:0]   rdAddrA,
  input  logic               rdEnB,
  input  logic [IDX_W-1:0]   rdAddrB,
  output rfStrobes_t         strobes,
  output logic [REG_CNT-1:0] validMask,
  output logic               illegalRead,
  output logic               illegalWrite
);

  logic                 wrLegal;
  logic [ADDR_SPAN-1:0] validPad;

  assign wrLegal      = (wrAddr < IDX_W'(FP_IDX));
  assign illegalWrite = wrEn && !wrLegal;

  // Priority: start, then call completion, then a normal write
  always_comb begin
    strobes.loadStart = start;
    strobes.loadCall  = callDone && !start;
    strobes.commitWr  = wrEn && wrLegal && !start && !callDone;
    strobes.wrIdx     = wrAddr;
    strobes.wrWide    = wrWide;
  end

  for (genvar i = 0; i < REG_CNT; i++) begin : g_valid
    localparam bit IS_ARG   = (i >= ARG_FIRST) && (i <= ARG_LAST);
    localparam bit IS_RET   = (i == RET_IDX);
    localparam bit AT_START = (i == CTX_IDX) || (i == FP_IDX);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validMask[i] <= 1'b0;
      end else if (strobes.loadStart) begin
        validMask[i] <= AT_START;
      end else if (strobes.loadCall) begin
        if (IS_RET)      validMask[i] <= 1'b1;
        else if (IS_ARG) validMask[i] <= 1'b0;
      end else if (strobes.commitWr && (strobes.wrIdx == IDX_W'(i))) begin
        validMask[i] <= 1'b1;
      end
    end
  end

  assign validPad    = {{(ADDR_SPAN-REG_CNT){1'b0}}, validMask};
  assign illegalRead = (rdEnA && !validPad[rdAddrA]) ||
                       (rdEnB && !validPad[rdAddrB]);

endmodule

// File: rtl/scrub_rf_rdport.sv
module scrub_rf_rdport
  import scrub_rf_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0]  regArr [REG_CNT],
  input  logic [REG_CNT-1:0] validMask,
  input  logic [IDX_W-1:0]   addr,
  output logic [DATA_W-1:0]  data
);

  always_comb begin
    data = '0;
    for (int i = 0; i < REG_CNT; i++) begin
      if ((addr == IDX_W'(i)) && validMask[i]) data = regArr[i];
    end
  end

endmodule

// File: rtl/scrub_rf_dpath.sv
module scrub_rf_dpath
  import scrub_rf_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  rfStrobes_t         strobes,
  input  logic [REG_CNT-1:0] validMask,
  input  logic [DATA_W-1:0]  ctxPtr,
  input  logic [DATA_W-1:0]  framePtr,
  input  logic [DATA_W-1:0]  callRet,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [IDX_W-1:0]   rdAddrA,
  input  logic [IDX_W-1:0]   rdAddrB,
  output logic [DATA_W-1:0]  rdDataA,
  output logic [DATA_W-1:0]  rdDataB
);

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] regArr [REG_CNT];
  logic [DATA_W-1:0] wrValue;

  assign wrValue = strobes.wrWide ? wrData
                                  : {{(DATA_W-HALF_W){1'b0}}, wrData[HALF_W-1:0]};

  for (genvar i = 0; i < REG_CNT; i++) begin : g_reg
    if (i == FP_IDX) begin : g_fp
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                  regArr[i] <= '0;
        else if (strobes.loadStart) regArr[i] <= framePtr;
      end
    end else begin : g_gp
      localparam bit IS_RET = (i == RET_IDX);
      localparam bit IS_CTX = (i == CTX_IDX);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          regArr[i] <= '0;
        end else if (strobes.loadStart) begin
          regArr[i] <= IS_CTX ? ctxPtr : '0;
        end else if (strobes.loadCall) begin
          if (IS_RET) regArr[i] <= callRet;
        end else if (strobes.commitWr && (strobes.wrIdx == IDX_W'(i))) begin
          regArr[i] <= wrValue;
        end
      end
    end
  end

  scrub_rf_rdport #(.DATA_W(DATA_W)) u_portA (
    .regArr(regArr), .validMask(validMask), .addr(rdAddrA), .data(rdDataA)
  );

  scrub_rf_rdport #(.DATA_W(DATA_W)) u_portB (
    .regArr(regArr), .validMask(validMask), .addr(rdAddrB), .data(rdDataB)
  );

endmodule

// File: rtl/scrub_regfile.sv
module scrub_regfile
  import scrub_rf_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] ctxPtr,
  input  logic [DATA_W-1:0] framePtr,
  input  logic              callDone,
  input  logic [DATA_W-1:0] callRet,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic              wrWide,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEnA,
  input  logic [IDX_W-1:0]  rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic              rdEnB,
  input  logic [IDX_W-1:0]  rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  output logic              illegalRead,
  output logic              illegalWrite
);

  rfStrobes_t         strobes;
  logic [REG_CNT-1:0] validMask;

  scrub_rf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .callDone(callDone),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrWide(wrWide),
    .rdEnA(rdEnA), .rdAddrA(rdAddrA), .rdEnB(rdEnB), .rdAddrB(rdAddrB),
    .strobes(strobes), .validMask(validMask),
    .illegalRead(illegalRead), .illegalWrite(illegalWrite)
  );

  scrub_rf_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .validMask(validMask),
    .ctxPtr(ctxPtr), .framePtr(framePtr), .callRet(callRet), .wrData(wrData),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB), .rdDataA(rdDataA), .rdDataB(rdDataB)
  );

endmodule

// File: rtl/scrub_rf_checker.sv
module scrub_rf_checker
  import scrub_rf_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [DATA_W-1:0] ctxPtr,
  input logic              callDone,
  input logic [DATA_W-1:0] callRet,
  input logic              wrEn,
  input logic [IDX_W-1:0]  wrAddr,
  input logic              wrWide,
  input logic              rdEnA,
  input logic [IDX_W-1:0]  rdAddrA,
  input logic [DATA_W-1:0] rdDataA,
  input logic              rdEnB,
  input logic              illegalRead,
  input logic              illegalWrite
);

  localparam int HALF_W = DATA_W / 2;

  // R1
  a_r1_fp_write_flag: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrAddr >= IDX_W'(FP_IDX))) |-> illegalWrite);

  // R2
  a_r2_narrow_zero_ext: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrWide && !start && !callDone && (wrAddr < IDX_W'(FP_IDX)))
    |=> ((rdAddrA != $past(wrAddr)) || (rdDataA[DATA_W-1:HALF_W] == '0)));

  // R3
  a_r3_ret_value: assert property (@(posedge clk) disable iff (!rstN)
    (callDone && !start) |=> ((rdAddrA != IDX_W'(RET_IDX)) || (rdDataA == $past(callRet))));

  // R3
  a_r3_args_scrubbed: assert property (@(posedge clk) disable iff (!rstN)
    (callDone && !start) |=>
    (!(rdEnA && (rdAddrA >= IDX_W'(ARG_FIRST)) && (rdAddrA <= IDX_W'(ARG_LAST))) ||
     (illegalRead && (rdDataA == '0))));

  // R5
  a_r5_ctx_loaded: assert property (@(posedge clk) disable iff (!rstN)
    start |=> ((rdAddrA != IDX_W'(CTX_IDX)) || (rdDataA == $past(ctxPtr))));

  // R6
  a_r6_bad_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEnA && !rdEnB && illegalRead) |-> (rdDataA == '0));

  // R6
  a_r6_high_index_flag: assert property (@(posedge clk) disable iff (!rstN)
    (rdEnA && (rdAddrA > IDX_W'(FP_IDX))) |-> illegalRead);

endmodule

bind scrub_regfile scrub_rf_checker #(.DATA_W(DATA_W)) u_checker (
  .clk(clk), .rstN(rstN), .start(start), .ctxPtr(ctxPtr),
  .callDone(callDone), .callRet(callRet), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrWide(wrWide), .rdEnA(rdEnA), .rdAddrA(rdAddrA), .rdDataA(rdDataA),
  .rdEnB(rdEnB), .illegalRead(illegalRead), .illegalWrite(illegalWrite)
);

// File: tb/test_scrub_regfile.sv
`timescale 1ns/1ps
module test_scrub_regfile;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [63:0] ctxPtr = '0, framePtr = '0, callRet = '0, wrData = '0;
  logic        callDone = 1'b0, wrEn = 1'b0, wrWide = 1'b0;
  logic [3:0]  wrAddr = '0, rdAddrA = '0, rdAddrB = '0;
  logic        rdEnA = 1'b0, rdEnB = 1'b0;
  logic [63:0] rdDataA, rdDataB;
  logic        illegalRead, illegalWrite;

  always #5 clk = ~clk;

  scrub_regfile i_scrub_regfile (
    .clk(clk), .rstN(rstN), .start(start), .ctxPtr(ctxPtr), .framePtr(framePtr),
    .callDone(callDone), .callRet(callRet), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrWide(wrWide), .wrData(wrData), .rdEnA(rdEnA), .rdAddrA(rdAddrA),
    .rdDataA(rdDataA), .rdEnB(rdEnB), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .illegalRead(illegalRead), .illegalWrite(illegalWrite)
  );

  // Behavioural reference
  logic [63:0] mReg [16];
  bit          mVal [16];
  int          total = 0;
  int          bad = 0;
  bit          finished = 0;
  string       tag = "R9";

  function automatic void modelClear();
    for (int i = 0; i < 16; i++) begin mReg[i] = '0; mVal[i] = 0; end
  endfunction

  function automatic logic [63:0] expRead(logic [3:0] a);
    return mVal[a] ? mReg[a] : 64'd0;
  endfunction

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    logic expIr;
    expIr = (rdEnA && !mVal[rdAddrA]) || (rdEnB && !mVal[rdAddrB]);
    chk("rdDataA", rdDataA, expRead(rdAddrA));
    chk("rdDataB", rdDataB, expRead(rdAddrB));
    chk("illegalRead", 64'(illegalRead), 64'(expIr));
    chk("illegalWrite", 64'(illegalWrite), 64'(wrEn && (wrAddr >= 4'd10)));
  endtask

  task automatic modelEdge();
    if (!rstN) modelClear();
    else if (start) begin
      modelClear();
      mReg[1] = ctxPtr; mVal[1] = 1;
      mReg[10] = framePtr; mVal[10] = 1;
    end else if (callDone) begin
      mReg[0] = callRet; mVal[0] = 1;
      for (int i = 1; i <= 5; i++) mVal[i] = 0;
    end else if (wrEn && wrAddr < 4'd10) begin
      mReg[wrAddr] = wrWide ? wrData : {32'd0, wrData[31:0]};
      mVal[wrAddr] = 1;
    end
  endtask

  // One cycle: inputs already set after a falling edge
  task automatic tick();
    #1 compareAll();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
  endtask

  task automatic idle();
    start = 0; callDone = 0; wrEn = 0;
  endtask

  // Sweep reads over every index without writes
  task automatic sweep();
    idle();
    for (int a = 0; a < 16; a += 2) begin
      rdEnA = 1; rdEnB = 1; rdAddrA = 4'(a); rdAddrB = 4'(a + 1);
      #1 compareAll();
    end
    tick();
  endtask

  task automatic doWrite(int a, logic wide, logic [63:0] d);
    idle(); wrEn = 1; wrAddr = 4'(a); wrWide = wide; wrData = d;
    rdEnA = 1; rdAddrA = 4'(a); rdEnB = 0;
    tick();
    wrEn = 0;
  endtask

  initial begin
    modelClear();
    // R9: reset state
    @(negedge clk);
    tag = "R9";
    sweep();
    rstN = 1;
    @(negedge clk);
    tag = "R9"; sweep();

    // R5: start, also overriding a call and a write
    tag = "R5";
    ctxPtr = 64'hC0DE_0000_1234_5678; framePtr = 64'hF00D_0000_0000_0200;
    start = 1; callDone = 1; callRet = 64'hBAD; wrEn = 1; wrAddr = 4'd1; wrWide = 1;
    wrData = 64'hDEAD;
    tick(); idle(); sweep();

    // R7: full writes to every writable index
    tag = "R7";
    for (int i = 0; i < 10; i++) doWrite(i, 1, {32'hA5A5_0000 + 32'(i), 32'h1111_0000 + 32'(i)});
    sweep();

    // R2: narrow writes with upper data bits set
    tag = "R2";
    for (int i = 0; i < 10; i++) doWrite(i, 0, {32'hFFFF_FFFF, 32'h7700_0000 + 32'(i)});
    sweep();
    doWrite(4, 1, 64'hFFFF_FFFF_8000_0001);
    sweep();

    // R1: frame pointer and nonexistent indices are read-only
    tag = "R1";
    doWrite(10, 1, 64'h1);
    doWrite(13, 1, 64'h2);
    doWrite(15, 0, 64'h3);
    sweep();

    // R8: call with concurrent writes to an argument and a callee-saved register
    tag = "R8";
    idle(); callDone = 1; callRet = 64'h0123_4567_89AB_CDEF;
    wrEn = 1; wrAddr = 4'd7; wrWide = 1; wrData = 64'h7777;
    tick(); idle(); sweep();
    tag = "R3"; sweep();
    idle(); callDone = 1; callRet = 64'h55; wrEn = 1; wrAddr = 4'd2; wrData = 64'h22;
    tick(); idle();
    tag = "R3"; sweep();
    tag = "R4"; sweep();

    // R7: argument register becomes readable again after a write
    tag = "R7";
    doWrite(3, 0, 64'h3333);
    sweep();

    // R6: randomized mix
    tag = "R6";
    for (int n = 0; n < 3000; n++) begin
      start    = ($urandom_range(0, 99) < 2);
      callDone = ($urandom_range(0, 99) < 10);
      callRet  = {$urandom, $urandom};
      ctxPtr   = {$urandom, $urandom};
      framePtr = {$urandom, $urandom};
      wrEn     = ($urandom_range(0, 99) < 60);
      wrAddr   = 4'($urandom_range(0, 15));
      wrWide   = 1'($urandom);
      wrData   = {$urandom, $urandom};
      rdEnA    = 1'($urandom); rdAddrA = 4'($urandom_range(0, 15));
      rdEnB    = 1'($urandom); rdAddrB = 4'($urandom_range(0, 15));
      tick();
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule